// File: doc/BRIEF.md
# Two-Level Input Current Limit Sequencer

This block schedules a temporary raise of the input current limit of a power path. A source can usually deliver more than its continuous rating for a short time. The block uses that margin during a load transient. In the quiet state it presents the base (level-1) limit code. When a qualified trigger arrives, it raises the limit to a level-2 code for an overload window. It then falls back to the base code for the rest of a fixed cycle. Charging is paused during that fallback part of the cycle.

Both windows are counted in ticks of a prescaled timebase. The overload window is `ovl_ticks` long and the whole cycle is `cyc_ticks` long. If the load is still high when the cycle expires, a fresh cycle starts at once. The block has two trigger sources, each with its own enable: a system-voltage-undershoot flag for a depleted or missing battery, and an input-current-overshoot flag qualified by battery discharge. The block runs only while input current management is on and the external limit mode is off. All comparator results arrive as synchronous flags.

Top module: `pkpwr_seq`

## Requirements
- R1: A synchronous active-low `rst_n` puts the block in idle: `phase` = 2'b00, `lim_code` = `base_code`, `chg_en` = 1, `cyc_start` = 0.
- R2: While idle, `lim_code` equals `base_code` and `chg_en` is 1.
- R3: In the overload phase, `lim_code` is floor(`base_code` × `ovl_pct` / 100), saturated to 2^CODE_W − 1.
- R4: An idle block enters the overload phase (`phase` = 2'b01) on the clock after a trigger is seen. A trigger is `sys_low` when `trig_sys_en` = 1, or `iin_high` together with `bat_dsg` when `trig_iin_en` = 1. Any flag whose enable is clear, and `iin_high` without `bat_dsg`, is ignored.
- R5: The block is allowed to run only while `dpm_en` = 1, `ext_lim` = 0, and at least one trigger enable is set. When this is not true, triggers are ignored, and any running cycle returns to idle on the next clock.
- R6: Ticks are counted from the start of a cycle. The overload phase ends on the tick at which the count reaches `ovl_ticks`, and the block then enters the base phase (`phase` = 2'b10). The cycle ends on the tick at which the count reaches `cyc_ticks`.
- R7: `chg_en` is 0 exactly while in the base phase, and it is back to 1 once the cycle ends.
- R8: If `ovl_ticks` ≥ `cyc_ticks`, the overload phase lasts until the cycle ends and the base phase never occurs.
- R9: If `load_high` = 1 on the tick that ends a cycle, a new cycle starts at once in the overload phase, with no idle cycle in between. Otherwise the block returns to idle.
- R10: `cyc_start` is a one-clock pulse, high in the first clock of every cycle, including cycles started by re-arming.
- R11: The timers advance only on clocks where `tick` = 1. Without ticks the phase is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse that advances the timers |
| base_code | input | CODE_W | Level-1 (base) limit code |
| ovl_pct | input | PCT_W | Level-2 limit as a percentage of the base code |
| ovl_ticks | input | TMR_W | Overload window length in ticks |
| cyc_ticks | input | TMR_W | Full cycle length in ticks |
| dpm_en | input | 1 | Input current management enabled |
| ext_lim | input | 1 | External limit mode (blocks operation) |
| trig_sys_en | input | 1 | Enable for the system-undershoot trigger |
| trig_iin_en | input | 1 | Enable for the input-overshoot trigger |
| sys_low | input | 1 | System voltage below the minimum setting |
| iin_high | input | 1 | Input current above the level-1 limit |
| bat_dsg | input | 1 | Battery is discharging |
| load_high | input | 1 | Load still high |
| lim_code | output | CODE_W | Active input current limit code |
| chg_en | output | 1 | Charging allowed |
| phase | output | 2 | 00 idle, 01 overload, 10 base |
| cyc_start | output | 1 | Pulse on each cycle start |

## Verification
The end of a cycle and the start of the next one can fall in the same clock. The bench provokes this by holding `load_high` across the final tick of a cycle. It judges the result by requiring `phase` to go straight from base to overload with `cyc_start` high and no idle sample in between, and by requiring the restarted cycle to run its full length. A second collision is a prerequisite being dropped while a cycle is running. Here the abort must win on the next clock, whatever the count is.

// File: rtl/pkpwr_seq.sv
module pkpwr_seq #(
  parameter int CODE_W = 8,
  parameter int PCT_W  = 8,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] base_code,
  input  logic [PCT_W-1:0]  ovl_pct,
  input  logic [TMR_W-1:0]  ovl_ticks,
  input  logic [TMR_W-1:0]  cyc_ticks,
  input  logic              dpm_en,
  input  logic              ext_lim,
  input  logic              trig_sys_en,
  input  logic              trig_iin_en,
  input  logic              sys_low,
  input  logic              iin_high,
  input  logic              bat_dsg,
  input  logic              load_high,
  output logic [CODE_W-1:0] lim_code,
  output logic              chg_en,
  output logic [1:0]        phase,
  output logic              cyc_start
);
  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_OVL  = 2'b01;
  localparam logic [1:0] PH_BASE = 2'b10;
  localparam int PROD_W = CODE_W + PCT_W;
  localparam logic [PROD_W-1:0] CODE_MAX = PROD_W'({CODE_W{1'b1}});

  logic [1:0]        ph_q, ph_d;
  logic [TMR_W-1:0]  cnt_q, cnt_d;
  logic              start_d;
  logic [PROD_W-1:0] prod, quot;
  logic [CODE_W-1:0] lvl2;
  logic [TMR_W:0]    cnt_inc;
  logic              allowed, trig, hit_ovl, hit_cyc;

  assign prod = PROD_W'(base_code) * PROD_W'(ovl_pct);
  assign quot = prod / PROD_W'(100);
  assign lvl2 = (quot > CODE_MAX) ? {CODE_W{1'b1}} : quot[CODE_W-1:0];

  assign allowed = dpm_en && !ext_lim && (trig_sys_en || trig_iin_en);
  assign trig    = (trig_sys_en && sys_low) || (trig_iin_en && iin_high && bat_dsg);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign hit_ovl = cnt_inc >= {1'b0, ovl_ticks};
  assign hit_cyc = cnt_inc >= {1'b0, cyc_ticks};

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    if (!allowed) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (trig) begin
          ph_d    = PH_OVL;
          cnt_d   = '0;
          start_d = 1'b1;
        end
        PH_OVL, PH_BASE: if (tick) begin
          if (hit_cyc) begin
            cnt_d   = '0;
            ph_d    = load_high ? PH_OVL : PH_IDLE;
            start_d = load_high;
          end else begin
            cnt_d = cnt_inc[TMR_W-1:0];
            if (ph_q == PH_OVL && hit_ovl) ph_d = PH_BASE;
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      cyc_start <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      cnt_q     <= cnt_d;
      cyc_start <= start_d;
    end
  end

  assign phase    = ph_q;
  assign lim_code = (ph_q == PH_OVL) ? lvl2 : base_code;
  assign chg_en   = (ph_q != PH_BASE);
endmodule

module pkpwr_seq_chk #(
  parameter int CODE_W = 8,
  parameter int PCT_W  = 8,
  parameter int TMR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CODE_W-1:0] base_code,
  input logic [PCT_W-1:0]  ovl_pct,
  input logic              dpm_en,
  input logic              ext_lim,
  input logic              trig_sys_en,
  input logic              trig_iin_en,
  input logic [CODE_W-1:0] lim_code,
  input logic              chg_en,
  input logic [1:0]        phase,
  input logic              cyc_start
);
  logic ok_run;
  assign ok_run = dpm_en && !ext_lim && (trig_sys_en || trig_iin_en);

  // R5
  a_r5_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_run |=> phase == 2'b00);
  // R10
  a_r10_start_in_overload: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> phase == 2'b01);
  a_r10_entry_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b01 && $past(phase) != 2'b01) |-> cyc_start);
  // R6
  a_r6_base_after_overload: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'b10 |-> ($past(phase) == 2'b01 || $past(phase) == 2'b10));
  // R7
  a_r7_base_blocks_charge: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'b10 |-> (!chg_en && lim_code == base_code));
  // R11
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && ok_run && phase != 2'b00) |=> $stable(phase));
  // R3
  a_r3_raise_not_below_base: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b01 && ovl_pct >= PCT_W'(100)) |-> lim_code >= base_code);
endmodule

bind pkpwr_seq pkpwr_seq_chk #(.CODE_W(CODE_W), .PCT_W(PCT_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .base_code(base_code), .ovl_pct(ovl_pct),
  .dpm_en(dpm_en), .ext_lim(ext_lim), .trig_sys_en(trig_sys_en),
  .trig_iin_en(trig_iin_en), .lim_code(lim_code), .chg_en(chg_en),
  .phase(phase), .cyc_start(cyc_start));

// File: tb/pkpwr_seq_bench.sv
module pkpwr_seq_bench;
  logic clk = 1'b0;
  logic rst_n, tick;
  logic [7:0] base_code, ovl_pct;
  logic [15:0] ovl_ticks, cyc_ticks;
  logic dpm_en, ext_lim, trig_sys_en, trig_iin_en;
  logic sys_low, iin_high, bat_dsg, load_high;
  logic [7:0] lim_code;
  logic chg_en, cyc_start;
  logic [1:0] phase;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pkpwr_seq u_pkpwr_seq (.*);

  // {base, pct, expected level-2 code}
  localparam logic [23:0] L2_VEC [10] = '{
    {8'd100, 8'd150, 8'd150}, {8'd200, 8'd150, 8'd255}, {8'd7,   8'd33,  8'd2},
    {8'd255, 8'd100, 8'd255}, {8'd0,   8'd200, 8'd0},   {8'd50,  8'd0,   8'd0},
    {8'd10,  8'd255, 8'd25},  {8'd99,  8'd101, 8'd99},  {8'd128, 8'd199, 8'd254},
    {8'd129, 8'd199, 8'd255}};

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fire_iin();
    trig_iin_en = 1; iin_high = 1; bat_dsg = 1;
    step();
    iin_high = 0; bat_dsg = 0;
  endtask

  initial begin
    rst_n = 0; tick = 1; base_code = 100; ovl_pct = 150; ovl_ticks = 3; cyc_ticks = 8;
    dpm_en = 1; ext_lim = 0; trig_sys_en = 1; trig_iin_en = 0;
    sys_low = 0; iin_high = 0; bat_dsg = 0; load_high = 0;
    step(2);
    check("R1 phase", phase, 0); check("R1 lim", lim_code, 100);
    check("R1 chg_en", chg_en, 1); check("R1 cyc_start", cyc_start, 0);
    rst_n = 1;

    // R4: disabled flag and unqualified overshoot ignored
    trig_sys_en = 0; trig_iin_en = 1; sys_low = 1; iin_high = 1; bat_dsg = 0;
    step(3);
    check("R4 ignored phase", phase, 0);
    check("R2 idle lim", lim_code, 100); check("R2 idle chg_en", chg_en, 1);
    // R5: prerequisites
    trig_sys_en = 1; bat_dsg = 1; dpm_en = 0;
    step(2); check("R5 dpm off", phase, 0);
    dpm_en = 1; ext_lim = 1;
    step(2); check("R5 ext on", phase, 0);
    ext_lim = 0; sys_low = 0; iin_high = 0; bat_dsg = 0; trig_iin_en = 0;

    // R6 R7 R10: undershoot trigger, full cycle
    sys_low = 1;
    step();
    sys_low = 0;
    for (int i = 0; i < 3; i++) begin
      check("R6 overload phase", phase, 1); check("R3 lim", lim_code, 150);
      check("R7 chg_en", chg_en, 1); check("R10 cyc_start", cyc_start, (i == 0) ? 1 : 0);
      step();
    end
    for (int i = 0; i < 5; i++) begin
      check("R6 base phase", phase, 2); check("R7 chg off", chg_en, 0);
      check("R7 lim", lim_code, 100);
      step();
    end
    check("R6 end idle", phase, 0); check("R7 chg back", chg_en, 1);

    // R4 overshoot trigger and R9 re-arm
    trig_sys_en = 0;
    fire_iin();
    check("R4 iin trigger", phase, 1);
    load_high = 1;
    step(7);
    check("R9 last base", phase, 2);
    step();
    check("R9 rearm phase", phase, 1); check("R9 rearm pulse", cyc_start, 1);
    load_high = 0;
    step(8);
    check("R9 after rearm idle", phase, 0);

    // R11 tick gating
    fire_iin();
    tick = 0;
    step(10);
    check("R11 hold", phase, 1);
    tick = 1;
    step(2); check("R11 resume", phase, 1);
    step(); check("R11 to base", phase, 2);
    // R5 abort
    dpm_en = 0;
    step(); check("R5 abort phase", phase, 0); check("R5 abort chg", chg_en, 1);
    dpm_en = 1;
    fire_iin();
    trig_iin_en = 0; trig_sys_en = 0;
    step(); check("R5 enables cleared", phase, 0);

    // R8 overload window not shorter than the cycle
    ovl_ticks = 5; cyc_ticks = 4;
    fire_iin();
    for (int i = 0; i < 4; i++) begin
      check("R8 overload held", phase, 1);
      step();
    end
    check("R8 idle no base", phase, 0);

    // R3 table
    ovl_ticks = 200; cyc_ticks = 250; tick = 0;
    fire_iin();
    foreach (L2_VEC[i]) begin
      base_code = L2_VEC[i][23:16]; ovl_pct = L2_VEC[i][15:8];
      #1;
      check("R3 level2 code", lim_code, L2_VEC[i][7:0]);
    end

    // R1 reset mid-cycle
    rst_n = 0;
    step();
    check("R1 mid reset phase", phase, 0); check("R1 mid reset lim", lim_code, base_code);
    rst_n = 1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule